// File: doc/BRIEF.md
# Counted Bulk-Read SPI Master

This block is an SPI master that moves data blocks between a memory card and a DMA engine. A transfer is armed with a byte count and launched by a start strobe. The active-low slave select goes low at launch and stays low until software sends a separate release command, so the card's command framing stays under software control. SCK idles low. Bits move most significant first in mode 0 timing: MOSI changes after a falling SCK edge and MISO is captured on a rising one.

There are two transfer modes. In write mode every byte is taken from a valid/ready transmit stream, and the bytes received alongside are discarded. In bulk-read mode the master clocks out an all-ones filler byte on its own for every counted byte. Each byte it receives leaves on a valid/ready receive stream, so nothing has to be written or cleared per byte. Back-pressure on either stream only stretches the gap between bytes, with SCK held low. No bit is ever dropped.

Top module: `spi_bulk_master`

## Requirements
- R1: After reset ss_n is 1, sck is 0, busy and done are 0, and rx_valid is 0.
- R2: A cmd_start pulse while idle with a nonzero cmd_count drives ss_n low and raises busy. A cmd_start with cmd_count equal to 0 changes nothing.
- R3: In bulk-read mode (cmd_bulk=1) every byte shifted out on MOSI is 0xFF, and tx_ready stays 0 for the whole transfer.
- R4: MOSI is stable while SCK is high. MISO is sampled on each SCK rising edge. Each byte is 8 bits, most significant bit first.
- R5: In bulk-read mode exactly cmd_count bytes appear on the receive stream, in the order they were received from MISO.
- R6: While rx_valid=1 and rx_ready=0, rx_valid and rx_data hold steady and SCK stays low. No further byte starts until the held byte is accepted.
- R7: In write mode (cmd_bulk=0) exactly cmd_count bytes are taken from the transmit stream and sent MSB first. When tx_valid is low, SCK waits low. rx_valid stays 0 throughout.
- R8: Each SCK phase lasts cfg_half clock cycles, with a value of 0 treated as 1.
- R9: After the last counted byte, done rises and busy falls, while ss_n stays low.
- R10: cmd_release raises ss_n only while idle. A cmd_start or cmd_release during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_half | input | DIV_W | System clocks per SCK phase (0 acts as 1) |
| cmd_start | input | 1 | Launch strobe for a counted transfer |
| cmd_bulk | input | 1 | Mode at launch: 1 bulk read, 0 write |
| cmd_count | input | CNT_W | Bytes in the transfer, captured at launch |
| cmd_release | input | 1 | Raise slave select when idle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer finished; cleared at next launch |
| tx_valid | input | 1 | Transmit stream byte available |
| tx_ready | output | 1 | Master will take the transmit byte this cycle |
| tx_data | input | DATA_W | Transmit stream byte |
| rx_valid | output | 1 | Receive stream byte available |
| rx_ready | input | 1 | Sink accepts the receive byte |
| rx_data | output | DATA_W | Receive stream byte |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench builds the block with DATA_W=8, CNT_W=8 and DIV_W=4. The narrow divider keeps SCK phases short, so multi-byte transfers finish in a few hundred cycles. It also makes the divide-by-zero corner and several distinct phase lengths cheap to measure. A behavioural mode-0 slave supplies a computed byte pattern on MISO and captures MOSI. This lets the order of bytes and bits be checked in both directions, including under long receive stalls and gapped transmit input.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2,
    ST_PUSH  = 2'd3
  } ctl_state_t;
endpackage

// File: rtl/spi_bm_tick.sv
module spi_bm_tick #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] half,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  always_comb begin
    lim  = (half == '0) ? DIV_W'(1) : half;
    tick = run && (cnt == lim - DIV_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || !run) cnt <= '0;
    else if (tick)           cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_bm_shift.sv
module spi_bm_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  input  logic              tick,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              active,
  output logic              byte_done,
  output logic [DATA_W-1:0] dout
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [BIT_W-1:0]  bitc;

  assign mosi = tx_sh[DATA_W-1];
  assign dout = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '1;
      rx_sh     <= '0;
      bitc      <= '0;
      sck       <= 1'b0;
      active    <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (start) begin
        tx_sh  <= din;
        bitc   <= '0;
        sck    <= 1'b0;
        active <= 1'b1;
      end else if (active && tick) begin
        if (!sck) begin
          sck   <= 1'b1;
          rx_sh <= {rx_sh[DATA_W-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitc == LAST_BIT) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            bitc  <= bitc + BIT_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_bm_ctrl.sv
module spi_bm_ctrl
  import spi_bm_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_bulk,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_release,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] byte_rx,
  output logic              byte_start,
  output logic [DATA_W-1:0] byte_tx,
  output logic              ss_n,
  output logic              busy,
  output logic              done
);
  localparam logic [DATA_W-1:0] FILL = '1;

  ctl_state_t       st;
  logic             bulk_q;
  logic [CNT_W-1:0] remain;

  always_comb begin
    tx_ready   = (st == ST_FETCH) && !bulk_q;
    byte_start = (st == ST_FETCH) && (bulk_q || tx_valid);
    byte_tx    = bulk_q ? FILL : tx_data;
    busy       = (st != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bulk_q   <= 1'b0;
      remain   <= '0;
      ss_n     <= 1'b1;
      done     <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (cmd_start && cmd_count != '0) begin
            st     <= ST_FETCH;
            remain <= cmd_count;
            bulk_q <= cmd_bulk;
            ss_n   <= 1'b0;
            done   <= 1'b0;
          end else if (cmd_release) begin
            ss_n <= 1'b1;
          end
        end
        ST_FETCH: if (byte_start) st <= ST_RUN;
        ST_RUN: begin
          if (byte_done) begin
            remain <= remain - CNT_W'(1);
            if (bulk_q) begin
              rx_data  <= byte_rx;
              rx_valid <= 1'b1;
              st       <= ST_PUSH;
            end else if (remain == CNT_W'(1)) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st <= ST_FETCH;
            end
          end
        end
        ST_PUSH: begin
          if (rx_ready) begin
            rx_valid <= 1'b0;
            if (remain == '0) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              st <= ST_FETCH;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_bulk_master.sv
module spi_bulk_master #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_half,
  input  logic              cmd_start,
  input  logic              cmd_bulk,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              cmd_release,
  output logic              busy,
  output logic              done,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n
);
  logic              byte_start;
  logic [DATA_W-1:0] byte_tx;
  logic              byte_done;
  logic [DATA_W-1:0] byte_rx;
  logic              sh_active;
  logic              tick;

  spi_bm_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_bulk(cmd_bulk), .cmd_count(cmd_count),
    .cmd_release(cmd_release),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .byte_done(byte_done), .byte_rx(byte_rx),
    .byte_start(byte_start), .byte_tx(byte_tx),
    .ss_n(ss_n), .busy(busy), .done(done)
  );

  spi_bm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(sh_active), .restart(byte_start),
    .half(cfg_half), .tick(tick)
  );

  spi_bm_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(byte_start), .din(byte_tx),
    .tick(tick), .miso(miso), .sck(sck), .mosi(mosi),
    .active(sh_active), .byte_done(byte_done), .dout(byte_rx)
  );
endmodule

// File: rtl/spi_bulk_master_chk.sv
module spi_bulk_master_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              sck,
  input logic              mosi,
  input logic              ss_n
);
  AST_SCK_LOW_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sck); // R1
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi)); // R4
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R6
  AST_STALL_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !sck); // R6
  AST_TX_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (busy && !rx_valid)); // R7
  AST_SELECT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ss_n); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_DONE_KEEPS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !ss_n); // R9
endmodule

bind spi_bulk_master spi_bulk_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .sck(sck), .mosi(mosi), .ss_n(ss_n)
);

// File: tb/spi_bulk_master_test.sv
module spi_bulk_master_test;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  localparam int DIV_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DIV_W-1:0] cfg_half = '0;
  logic cmd_start = 1'b0, cmd_bulk = 1'b0, cmd_release = 1'b0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic busy, done, tx_ready, rx_valid, sck, mosi, ss_n;
  logic tx_valid = 1'b0;
  logic [DATA_W-1:0] tx_data = '0;
  logic rx_ready;
  logic [DATA_W-1:0] rx_data;
  logic miso;

  int vecs = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_bulk_master #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half),
    .cmd_start(cmd_start), .cmd_bulk(cmd_bulk), .cmd_count(cmd_count),
    .cmd_release(cmd_release), .busy(busy), .done(done),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int idx);
    return 8'((idx * 37 + 11) ^ (idx >> 2));
  endfunction

  // mode-0 slave model
  logic [7:0] slv_out = 8'd11;
  logic [7:0] slv_cap = '0;
  int slv_bits = 0, slv_idx = 0;
  logic [7:0] mosi_got[$];
  int sck_rises = 0;
  assign miso = slv_out[7];

  always @(posedge sck) begin
    sck_rises++;
    slv_cap = {slv_cap[6:0], mosi};
    slv_bits++;
    if (slv_bits == 8) begin
      mosi_got.push_back(slv_cap);
      slv_bits = 0;
      slv_idx++;
      slv_out = resp(slv_idx);
    end
  end
  always @(negedge sck) if (slv_bits != 0) slv_out = {slv_out[6:0], 1'b0};

  // receive sink driver
  int rx_mode = 0;
  int rx_tgl = 0;
  initial rx_ready = 1'b1;
  always @(posedge clk) begin
    #1;
    rx_tgl++;
    case (rx_mode)
      0: rx_ready = 1'b1;
      1: rx_ready = 1'b0;
      default: rx_ready = (rx_tgl % 3) != 0;
    endcase
  end

  // scoreboard monitor and phase observers
  logic [7:0] exp_rx[$];
  logic [7:0] exp_mosi[$];
  bit bulk_phase = 0, write_phase = 0;
  int txr_in_bulk = 0, rxv_in_write = 0;
  int hr_run = 0, hr_min = 1000, hr_max = 0;

  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_rx.size() == 0) begin
        check(0, "R5 unexpected rx byte", rx_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        check(rx_data == e, "R5 rx byte order", rx_data, e);
      end
    end
    if (bulk_phase && tx_ready) txr_in_bulk++;
    if (write_phase && rx_valid) rxv_in_write++;
    if (sck) hr_run++;
    else if (hr_run != 0) begin
      if (hr_run < hr_min) hr_min = hr_run;
      if (hr_run > hr_max) hr_max = hr_run;
      hr_run = 0;
    end
  end

  task automatic launch(input bit bulk, input int n);
    @(posedge clk); #1;
    cmd_start = 1'b1; cmd_bulk = bulk; cmd_count = CNT_W'(n);
    @(posedge clk); #1;
    cmd_start = 1'b0;
  endtask

  task automatic pulse_release();
    @(posedge clk); #1; cmd_release = 1'b1;
    @(posedge clk); #1; cmd_release = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    do begin @(negedge clk); n++; end while (!done && n < 20000);
  endtask

  task automatic expect_bulk(input int n);
    for (int k = 0; k < n; k++) begin
      exp_rx.push_back(resp(slv_idx + k));
      exp_mosi.push_back(8'hFF);
    end
  endtask

  task automatic compare_mosi(input string req);
    check(mosi_got.size() == exp_mosi.size(), req, mosi_got.size(), exp_mosi.size());
    while (mosi_got.size() > 0 && exp_mosi.size() > 0) begin
      logic [7:0] g, e;
      g = mosi_got.pop_front();
      e = exp_mosi.pop_front();
      check(g == e, req, g, e);
    end
    mosi_got.delete(); exp_mosi.delete();
  endtask

  task automatic send_tx(input logic [7:0] v, input int gap);
    @(posedge clk); #1;
    tx_valid = 1'b1; tx_data = v;
    do @(negedge clk); while (!tx_ready);
    @(posedge clk); #1;
    tx_valid = 1'b0; tx_data = 8'h00;
    repeat (gap) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ss_n == 1'b1, "R1 ss_n", ss_n, 1);
    check(sck == 1'b0, "R1 sck", sck, 0);
    check(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
    check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);

    // R2 zero count launches nothing
    launch(1'b1, 0);
    repeat (5) @(negedge clk);
    check(ss_n == 1'b1 && busy == 1'b0, "R2 zero count ignored", {ss_n, busy}, 2'b10);

    // bulk read, 4 bytes, half=2
    cfg_half = 4'd2;
    hr_min = 1000; hr_max = 0;
    expect_bulk(4);
    bulk_phase = 1;
    launch(1'b1, 4);
    @(negedge clk);
    check(ss_n == 1'b0 && busy == 1'b1, "R2 launch selects", {ss_n, busy}, 2'b01);
    wait_done();
    bulk_phase = 0;
    check(done == 1'b1 && busy == 1'b0, "R9 done after count", {done, busy}, 2'b10);
    check(ss_n == 1'b0, "R9 select held after done", ss_n, 0);
    check(exp_rx.size() == 0, "R5 all bulk bytes delivered", exp_rx.size(), 0);
    check(txr_in_bulk == 0, "R3 tx_ready idle in bulk", txr_in_bulk, 0);
    compare_mosi("R3 filler on mosi");
    check(hr_min == 2 && hr_max == 2, "R8 sck phase half=2", hr_max, 2);

    // R10 release while idle
    pulse_release();
    @(negedge clk);
    check(ss_n == 1'b1, "R10 release when idle", ss_n, 1);

    // write mode, 5 bytes with gaps, half=1
    cfg_half = 4'd1;
    hr_min = 1000; hr_max = 0;
    write_phase = 1;
    launch(1'b0, 5);
    for (int k = 0; k < 5; k++) begin
      logic [7:0] v;
      v = 8'(8'h81 + k * 8'h36);
      exp_mosi.push_back(v);
      send_tx(v, k * 7);
    end
    wait_done();
    write_phase = 0;
    check(done == 1'b1, "R7 write finishes", done, 1);
    check(rxv_in_write == 0, "R7 no rx in write", rxv_in_write, 0);
    compare_mosi("R7 R4 write bytes msb first");
    check(hr_min == 1 && hr_max == 1, "R8 sck phase half=1", hr_max, 1);
    pulse_release();

    // R6 stall, plus R10 ignored commands during transfer
    cfg_half = 4'd3;
    rx_mode = 1;
    expect_bulk(3);
    begin
      int base;
      base = sck_rises;
      launch(1'b1, 3);
      repeat (300) @(negedge clk);
      check(sck_rises - base == 8, "R6 sck paused under backpressure", sck_rises - base, 8);
      check(rx_valid == 1'b1, "R6 byte held", rx_valid, 1);
      check(rx_data == exp_rx[0], "R6 held data", rx_data, exp_rx[0]);
    end
    launch(1'b1, 9);
    pulse_release();
    @(negedge clk);
    check(ss_n == 1'b0 && busy == 1'b1, "R10 commands ignored when busy", {ss_n, busy}, 2'b01);
    rx_mode = 0;
    wait_done();
    check(exp_rx.size() == 0, "R6 no byte lost", exp_rx.size(), 0);
    compare_mosi("R10 count unchanged by second launch");
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R10 no extra transfer", busy, 0);

    // half=0 acts as 1, toggling sink
    cfg_half = 4'd0;
    hr_min = 1000; hr_max = 0;
    rx_mode = 2;
    expect_bulk(6);
    launch(1'b1, 6);
    wait_done();
    rx_mode = 0;
    check(exp_rx.size() == 0, "R5 bytes under toggling ready", exp_rx.size(), 0);
    compare_mosi("R3 filler with half=0");
    check(hr_min == 1 && hr_max == 1, "R8 half=0 treated as 1", hr_max, 1);
    pulse_release();
    @(negedge clk);
    check(ss_n == 1'b1 && sck == 1'b0, "R1 idle after release", {ss_n, sck}, 2'b10);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule